// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches an 8-bit input port and keeps a sticky change flag. The raw pins first pass through a multi-flop synchroniser. The synchronised value is then compared with a reference latch. That latch holds the port value the CPU saw at its most recent port access. Only pins selected by an enable mask take part in the compare. As long as any enabled pin differs from the reference, the flag is set again on every clock. A software clear therefore only takes effect after a port read or write has refreshed the reference.

The flag drives two outputs. The wake output follows the flag alone, so the block can rouse a sleeping or idle core. The interrupt output is the flag gated by a global enable. The block has two reset inputs. Power-on reset clears everything, including the reference latch. Warm reset clears only the flag, so a mismatch that was pending before the reset raises the flag again once the reset is released.

A pin change that first appears at the synchroniser output in the same cycle as a port access is folded into the reference and raises no flag. This gives a fixed, repeatable rule for the case where a change and a read coincide.

Top module: `pin_change_monitor`

## Requirements
- R1: Power-on reset (`por_n` low) clears the flag, the synchroniser and the reference latch to zero. Afterwards, nonzero enabled pins set the flag on the third clock edge after release.
- R2: When an enabled pin (mask bit 1) differs from its reference bit, the flag is 1 on the third rising edge after the pin change, provided no port access occurs.
- R3: Pins whose `en_mask` bit is 0 never set the flag, whatever their value.
- R4: A cycle with `rd_stb` or `wr_stb` high loads the synchronised pin value into the reference latch on that edge. The latch holds its value in every other cycle.
- R5: Setting has priority over clearing. `clr_stb` clears the flag only in a cycle with no unsuppressed mismatch, so a clear during a persisting mismatch leaves the flag at 1.
- R6: Warm reset (`warm_rst_n` low) clears the flag and leaves the reference latch unchanged. The flag returns on the first edge after release if a mismatch remains.
- R7: In a cycle with a port access, a mismatch does not set the flag. A change that reaches the synchroniser output in that cycle is absorbed into the reference and is lost.
- R8: `irq_o` equals the flag AND `gie`. `wake_o` equals the flag regardless of `gie`.
- R9: `rd_data` is the synchronised pin value, which follows `pins_i` two edges later.
- R10: A single port access refreshes all eight reference bits at once, so changes on several pins are absorbed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; clears the flag only |
| pins_i | input | 8 | Raw asynchronous port pins |
| rd_stb | input | 1 | Port read access strobe |
| wr_stb | input | 1 | Port write access strobe |
| clr_stb | input | 1 | Software flag-clear strobe |
| en_mask | input | 8 | Per-pin compare enable |
| gie | input | 1 | Global interrupt enable |
| rd_data | output | 8 | Synchronised port value for the bus |
| chg_flag | output | 1 | Sticky change flag |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions assume that the strobes, mask and enable are synchronous to `clk`. They also assume that `por_n` is released away from a rising edge, so that the first edge after release sees a stable synchroniser. The bench drives every input at the falling edge. It holds each pin pattern long enough for the synchroniser to settle before it issues the next access. The only exception is the deliberate coincidence test, which places the pin change so that it reaches the synchroniser output in exactly the cycle of the read strobe.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam int PORT_W = 8;

  // Per-pin difference between live and reference, restricted to enabled pins
  function automatic logic [PORT_W-1:0] diff_vec(
    input logic [PORT_W-1:0] live,
    input logic [PORT_W-1:0] refv,
    input logic [PORT_W-1:0] mask
  );
    return (live ^ refv) & mask;
  endfunction

  // True when any enabled pin disagrees with the reference
  function automatic logic has_diff(
    input logic [PORT_W-1:0] live,
    input logic [PORT_W-1:0] refv,
    input logic [PORT_W-1:0] mask
  );
    return |diff_vec(live, refv, mask);
  endfunction

  // Next flag value: set dominates clear, otherwise hold
  function automatic logic flag_next(
    input logic cur,
    input logic set_req,
    input logic clr_req
  );
    if (set_req)      return 1'b1;
    else if (clr_req) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];

  // Stage chain, reset only by power-on so warm resets cause no glitch
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[LAST];

endmodule

// File: rtl/pcm_ref_latch.sv
module pcm_ref_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         load,
  input  logic [W-1:0] live,
  output logic [W-1:0] ref_q
);

  // Cleared only at power-on; any port access refreshes every bit together
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    ref_q <= '0;
    else if (load) ref_q <= live;
  end

endmodule

// File: rtl/pcm_flag.sv
module pcm_flag (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);

  import pcm_pkg::*;

  // Power-on is asynchronous; warm reset is sampled and clears the flag only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           flag_q <= 1'b0;
    else if (!warm_rst_n) flag_q <= 1'b0;
    else                  flag_q <= flag_next(flag_q, set_req, clr_req);
  end

endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         warm_rst_n,
  input  logic [W-1:0] pins_i,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] en_mask,
  input  logic         gie,
  output logic [W-1:0] rd_data,
  output logic         chg_flag,
  output logic         irq_o,
  output logic         wake_o
);

  import pcm_pkg::*;

  // Named internal events, visible to the bound checker
  logic [W-1:0] pin_sync;
  logic [W-1:0] ref_q;
  logic         access;
  logic         mismatch_any;
  logic         set_req;
  logic         flag;

  pcm_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .d_async(pins_i),
    .q_sync (pin_sync)
  );

  assign access = rd_stb | wr_stb;

  pcm_ref_latch #(.W(W)) u_ref (
    .clk  (clk),
    .por_n(por_n),
    .load (access),
    .live (pin_sync),
    .ref_q(ref_q)
  );

  assign mismatch_any = has_diff(pin_sync, ref_q, en_mask);
  // A mismatch in an access cycle is absorbed by the reference refresh
  assign set_req      = mismatch_any & ~access;

  pcm_flag u_flag (
    .clk       (clk),
    .por_n     (por_n),
    .warm_rst_n(warm_rst_n),
    .set_req   (set_req),
    .clr_req   (clr_stb),
    .flag_q    (flag)
  );

  assign rd_data  = pin_sync;
  assign chg_flag = flag;
  assign wake_o   = flag;
  assign irq_o    = flag & gie;

endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         por_n,
  input logic         warm_rst_n,
  input logic         access,
  input logic         clr_stb,
  input logic         gie,
  input logic         mismatch_any,
  input logic [W-1:0] ref_q,
  input logic [W-1:0] pin_sync,
  input logic         flag,
  input logic         irq_o,
  input logic         wake_o
);

  AST_SET_ON_MISMATCH: assert property (@(posedge clk) disable iff (!por_n)
    (mismatch_any && !access && warm_rst_n) |=> flag); // R2

  AST_RISE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag) |-> $past(mismatch_any && !access)); // R3

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!por_n)
    access |=> (ref_q == $past(pin_sync))); // R4

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !access |=> $stable(ref_q)); // R4

  AST_CLEAR_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flag) |-> ($past(!warm_rst_n) || $past(clr_stb && !(mismatch_any && !access)))); // R5

  AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> !flag); // R6

  AST_ACCESS_NO_SET: assert property (@(posedge clk) disable iff (!por_n)
    (access && !flag) |=> !flag); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!por_n)
    (!gie |-> !irq_o) and (wake_o == flag)); // R8

endmodule

bind pin_change_monitor pcm_checker #(.W(W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .warm_rst_n  (warm_rst_n),
  .access      (access),
  .clr_stb     (clr_stb),
  .gie         (gie),
  .mismatch_any(mismatch_any),
  .ref_q       (ref_q),
  .pin_sync    (pin_sync),
  .flag        (flag),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/pin_change_monitor_test.sv
module pin_change_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 13;

  // Vector: [31:24] pins, [23:16] mask, [15] gie, [14:12] op,
  // [11:8] requirement number, [2] flag, [1] irq, [0] wake.
  // op: 0 none, 2 write, 3 clear, 4 read then clear.
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00FF_8100, // R1 idle after power-on
    32'h05FF_8207, // R2 enabled pins differ
    32'h05FF_B507, // R5 clear loses to live mismatch
    32'h05FF_C500, // R5 read then clear
    32'h05FF_8400, // R4 reference holds the read value
    32'h0DF7_8300, // R3 masked pin changes
    32'h0DFF_0805, // R8 gie low: wake only
    32'h0DFF_A407, // R4 write keeps sticky flag
    32'h0DFF_B500, // R5 clear succeeds after write
    32'h30FF_CA00, // R10 multi-pin change absorbed by one read
    32'h3000_8300, // R3 empty mask
    32'hFF00_8300, // R3 empty mask, all pins high
    32'hFF80_8207  // R2 single enabled pin
  };

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst_n = 1'b1;
  logic [7:0] pins_i = '0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic       clr_stb = 1'b0;
  logic [7:0] en_mask = 8'hFF;
  logic       gie = 1'b1;
  logic [7:0] rd_data;
  logic       chg_flag, irq_o, wake_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  pin_change_monitor uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .pins_i(pins_i),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .clr_stb(clr_stb), .en_mask(en_mask),
    .gie(gie), .rd_data(rd_data), .chg_flag(chg_flag), .irq_o(irq_o),
    .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    if (which == 1) rd_stb = 1'b1;
    if (which == 2) wr_stb = 1'b1;
    if (which == 3) clr_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; clr_stb = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", chg_flag, 0);
    chk("R1 wake in reset", wake_o, 0);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 0);

    // Table walk: settle pins, optional access, then sample
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      int op, rq;
      v = VEC[i];
      pins_i = v[31:24]; en_mask = v[23:16]; gie = v[15];
      op = int'(v[14:12]); rq = int'(v[11:8]);
      repeat (3) @(negedge clk);
      if (op == 4) begin pulse(1); pulse(3); end
      else if (op != 0) pulse(op);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d flag", rq, i), chg_flag, int'(v[2]));
      chk($sformatf("R%0d vec%0d irq", rq, i), irq_o, int'(v[1]));
      chk($sformatf("R%0d vec%0d wake", rq, i), wake_o, int'(v[0]));
      chk($sformatf("R9 vec%0d rd_data", i), rd_data, int'(v[31:24]));
    end

    // R7: change reaches synchroniser output in the read cycle -> lost
    en_mask = 8'hFF; gie = 1'b1;
    pulse(1); pulse(3); @(negedge clk);
    chk("R5 resync clear", chg_flag, 0);
    pins_i = 8'h0F;
    @(negedge clk); @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 coincident change lost", chg_flag, 0);

    // R7 contrast: read one cycle early captures the old value
    pins_i = 8'hF0;
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
    chk("R7 early read keeps change", chg_flag, 1);

    // R6: warm reset clears flag, reference survives
    warm_rst_n = 1'b0;
    @(negedge clk);
    chk("R6 flag during warm reset", chg_flag, 0);
    chk("R6 wake during warm reset", wake_o, 0);
    warm_rst_n = 1'b1;
    @(negedge clk);
    chk("R6 flag returns after warm reset", chg_flag, 1);

    // R1: power-on reset zeroes the reference
    pulse(1); pulse(3); @(negedge clk);
    chk("R4 read equalises", chg_flag, 0);
    por_n = 1'b0;
    @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 0);
    por_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 no flag before third edge", chg_flag, 0);
    @(negedge clk);
    chk("R1 reference cleared by power-on", chg_flag, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule